// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block takes a USB low-speed differential pair, already brought into the local clock domain, and turns it into received bytes. The pair is sampled by an oversampling clock that runs at a nominal 11 clocks per bit. While the bus is idle the block waits for the first falling edge on D-, which is a J-to-K change. It then hunts through the sync field. It locks its bit timing when a K is followed by a second K one bit later, which is the pair that closes sync.

Once locked, the block samples every bit at its centre. It keeps the sample point aligned with the sender by moving it one clock on any transition that arrives off-centre. Each sampled level is NRZI-decoded and stuffed bits are discarded. The remaining bits are packed into bytes, least significant bit first.

Each finished byte is strobed out, written into a receive buffer of bounded size, and counted. A single-ended zero at a sample point closes the packet with a done pulse. A byte that would go past the buffer size aborts the packet with an overflow pulse. A failure to find sync in time gives a sync error pulse.

Top module: `usbls_rx`

## Requirements
- R1: The pair {dp, dm} is decoded as J = (0,1), K = (1,0) and SE0 = (0,0). The block idles in J, and a J-to-K change starts sync search.
- R2: Lock is taken when the bit one period after a J-to-K edge is also K. A J seen there resumes the search at the next J-to-K edge. The bit after the double K is the first data bit.
- R3: If SYNC_WAIT clocks pass during search without a new J-to-K edge and without lock, sync_err pulses for one clock and the block returns to idle with no byte output.
- R4: NRZI decoding is as follows. A sampled level equal to the previous bit gives 1 and a change gives 0. The reference at lock is K.
- R5: Bits are packed LSB first. Each completed byte gives a one-clock byte_vld pulse with the byte on byte_data.
- R6: After six consecutive decoded 1s, the next bit is discarded and is not placed in any byte. The final sync bit counts as the first 1.
- R7: SE0 at a bit sample ends the packet with a one-clock pkt_done pulse. Trailing bits that do not complete a byte are dropped. This also applies where a stuffed bit was due.
- R8: byte_count clears at lock, rises by one with each byte_vld, and holds its value after the packet ends.
- R9: A byte that would exceed BUF_BYTES pulses ovf_err instead of byte_vld. That byte is neither stored nor counted, no pkt_done follows, and the line is ignored until the next SE0.
- R10: Byte k of a packet is written at buffer address k. rd_data shows the entry at rd_addr one clock later.
- R11: Reception is error-free with a sender bit period between 10.9 and 11.1 clocks. The sample counter moves by one clock on each off-centre transition.
- R12: In reset all strobes are low, byte_count is zero and the line is taken as J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 11 per bit nominal |
| rst | input | 1 | Synchronous active-high reset |
| dp | input | 1 | Synchronized D+ sample |
| dm | input | 1 | Synchronized D- sample |
| byte_vld | output | 1 | One-clock strobe for a received byte |
| byte_data | output | 8 | Received byte |
| pkt_done | output | 1 | One-clock pulse at normal packet end |
| byte_count | output | clog2(BUF_BYTES+1) | Bytes stored for the current or last packet |
| sync_err | output | 1 | One-clock pulse on sync search timeout |
| ovf_err | output | 1 | One-clock pulse on buffer overflow |
| rd_addr | input | clog2(BUF_BYTES) | Buffer read address |
| rd_data | output | 8 | Buffer read data, one clock latency |

## Verification
The bench builds the block with BIT_CLKS = 11, SYNC_WAIT = 40 and BUF_BYTES = 4. With a four-entry buffer, a five-byte packet is enough to reach the overflow abort, followed by a clean recovery packet. With a 40-clock search window, one stray K followed by idle J reaches the timeout, while a broken preamble with a two-bit gap still locks. The sender period is set in tenths of a clock, at 10.9, 11.0 and 11.1, so that runs of ones that force stuffing test the one-clock phase nudging at both ends of the tolerance.

// File: rtl/usbls_rx_pkg.sv
package usbls_rx_pkg;
  // bus state, encoded as {dp, dm}
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_RECV,
    ST_DRAIN
  } rx_st_t;
endpackage

// File: rtl/usbls_line_in.sv
module usbls_line_in
  import usbls_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  dp,
  input  logic  dm,
  output line_t ln,
  output logic  jk_edge,
  output logic  jk_trans
);
  line_t ln_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ln   <= LN_J;
      ln_q <= LN_J;
    end else begin
      ln   <= line_t'({dp, dm});
      ln_q <= ln;
    end
  end

  assign jk_edge  = (ln == LN_K) && (ln_q == LN_J);
  assign jk_trans = jk_edge || ((ln == LN_J) && (ln_q == LN_K));

  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ln_q == LN_J));
endmodule

// File: rtl/usbls_bit_timer.sv
module usbls_bit_timer #(
  parameter int BIT_CLKS  = 11,
  parameter int SYNC_WAIT = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic lock,
  input  logic track,
  input  logic trans,
  output logic centre,
  output logic kk_point,
  output logic timeout
);
  localparam int HALF = BIT_CLKS / 2;
  localparam int CW   = $clog2(SYNC_WAIT + 1);
  localparam logic [CW-1:0] C_ZERO = '0;
  localparam logic [CW-1:0] C_ONE  = CW'(1);
  localparam logic [CW-1:0] C_HALF = CW'(HALF);
  localparam logic [CW-1:0] C_LOCK = CW'(HALF + 1);
  localparam logic [CW-1:0] C_KK   = CW'(HALF + BIT_CLKS);
  localparam logic [CW-1:0] C_LAST = CW'(BIT_CLKS - 1);
  localparam logic [CW-1:0] C_PEN  = CW'(BIT_CLKS - 2);
  localparam logic [CW-1:0] C_TMO  = CW'(SYNC_WAIT - 1);
  localparam logic [CW-1:0] C_SAT  = CW'(SYNC_WAIT);

  logic [CW-1:0] cnt, nxt;

  always_comb begin
    if (restart) begin
      nxt = C_ONE;                         // edge cycle counts as phase zero
    end else if (lock) begin
      nxt = C_LOCK;
    end else if (track) begin
      if (trans && (cnt != C_ZERO) && (cnt < C_HALF)) begin
        nxt = cnt;                         // edge arrived late: stretch one clock
      end else if (trans && (cnt > C_HALF)) begin
        if (cnt == C_LAST)     nxt = C_ONE; // edge arrived early: skip one clock
        else if (cnt == C_PEN) nxt = C_ZERO;
        else                   nxt = cnt + 2'd2;
      end else begin
        nxt = (cnt == C_LAST) ? C_ZERO : cnt + 1'b1;
      end
    end else begin
      nxt = (cnt == C_SAT) ? cnt : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= C_SAT;
    else     cnt <= nxt;
  end

  assign centre   = track && (cnt == C_HALF);
  assign kk_point = !track && (cnt == C_KK);
  assign timeout  = !track && (cnt == C_TMO);

  // R11
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    track |-> (cnt <= C_LAST));
  // R11
  single_sample_chk: assert property (@(posedge clk) disable iff (rst)
    centre |=> !centre);
endmodule

// File: rtl/usbls_bit_unstuff.sv
module usbls_bit_unstuff #(
  parameter int STUFF_RUN = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       smp,
  input  logic       lvl_j,
  output logic       byte_rdy,
  output logic [7:0] byte_nxt
);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam logic [OW-1:0] RUN_C = OW'(STUFF_RUN);

  logic          ref_j;
  logic [OW-1:0] ones;
  logic [2:0]    bitcnt;
  logic [7:0]    sr;
  logic          bit_v, stuff;

  assign bit_v    = (lvl_j == ref_j);
  assign stuff    = (ones == RUN_C);
  assign byte_nxt = {bit_v, sr[7:1]};
  assign byte_rdy = smp && !stuff && (bitcnt == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_j  <= 1'b1;
      ones   <= '0;
      bitcnt <= '0;
      sr     <= '0;
    end else if (start) begin
      ref_j  <= 1'b0;               // last sync bit is K
      ones   <= OW'(1);             // and decodes as a 1
      bitcnt <= '0;
    end else if (smp) begin
      ref_j <= lvl_j;
      if (stuff) begin
        ones <= '0;
      end else begin
        sr     <= byte_nxt;
        bitcnt <= bitcnt + 1'b1;
        ones   <= bit_v ? ones + 1'b1 : '0;
      end
    end
  end

  // R6
  ones_limit_chk: assert property (@(posedge clk) disable iff (rst)
    ones <= RUN_C);
  // R6
  stuff_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (smp && stuff && !start) |=> $stable(bitcnt));
endmodule

// File: rtl/usbls_rx.sv
module usbls_rx
  import usbls_rx_pkg::*;
#(
  parameter int BIT_CLKS  = 11,
  parameter int SYNC_WAIT = 40,
  parameter int BUF_BYTES = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               dp,
  input  logic                               dm,
  output logic                               byte_vld,
  output logic [7:0]                         byte_data,
  output logic                               pkt_done,
  output logic [$clog2(BUF_BYTES+1)-1:0]     byte_count,
  output logic                               sync_err,
  output logic                               ovf_err,
  input  logic [$clog2(BUF_BYTES)-1:0]       rd_addr,
  output logic [7:0]                         rd_data
);
  localparam int CW = $clog2(BUF_BYTES + 1);
  localparam int AW = $clog2(BUF_BYTES);
  localparam logic [CW-1:0] BUF_C = CW'(BUF_BYTES);

  line_t      ln;
  logic       jk_edge, jk_trans;
  logic       centre, kk_point, timeout;
  logic       restart, lock, track, smp, se0_hit, wr_en;
  logic       byte_rdy;
  logic [7:0] byte_nxt;
  rx_st_t     st;
  logic [7:0] mem [BUF_BYTES];

  usbls_line_in u_line (
    .clk(clk), .rst(rst), .dp(dp), .dm(dm),
    .ln(ln), .jk_edge(jk_edge), .jk_trans(jk_trans)
  );

  assign restart = jk_edge && ((st == ST_IDLE) || (st == ST_HUNT));
  assign lock    = (st == ST_HUNT) && !jk_edge && kk_point && (ln == LN_K);
  assign track   = (st == ST_RECV);

  usbls_bit_timer #(.BIT_CLKS(BIT_CLKS), .SYNC_WAIT(SYNC_WAIT)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .lock(lock), .track(track),
    .trans(jk_trans), .centre(centre), .kk_point(kk_point), .timeout(timeout)
  );

  assign smp     = centre && ((ln == LN_J) || (ln == LN_K));
  assign se0_hit = centre && (ln == LN_SE0);

  usbls_bit_unstuff #(.STUFF_RUN(6)) u_unstuff (
    .clk(clk), .rst(rst), .start(lock), .smp(smp), .lvl_j(ln == LN_J),
    .byte_rdy(byte_rdy), .byte_nxt(byte_nxt)
  );

  assign wr_en = track && byte_rdy && (byte_count != BUF_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      byte_vld   <= 1'b0;
      byte_data  <= '0;
      pkt_done   <= 1'b0;
      byte_count <= '0;
      sync_err   <= 1'b0;
      ovf_err    <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      pkt_done <= 1'b0;
      sync_err <= 1'b0;
      ovf_err  <= 1'b0;
      case (st)
        ST_IDLE: if (jk_edge) st <= ST_HUNT;
        ST_HUNT: begin
          if (lock) begin
            st         <= ST_RECV;
            byte_count <= '0;
          end else if (!jk_edge && timeout) begin
            st       <= ST_IDLE;
            sync_err <= 1'b1;
          end
        end
        ST_RECV: begin
          if (se0_hit) begin
            st       <= ST_IDLE;
            pkt_done <= 1'b1;
          end else if (byte_rdy) begin
            if (byte_count == BUF_C) begin
              st      <= ST_DRAIN;
              ovf_err <= 1'b1;
            end else begin
              byte_vld   <= 1'b1;
              byte_data  <= byte_nxt;
              byte_count <= byte_count + 1'b1;
            end
          end
        end
        ST_DRAIN: if (ln == LN_SE0) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // buffer: write port fed by the receiver, registered read port
  always_ff @(posedge clk) begin
    if (wr_en) mem[byte_count[AW-1:0]] <= byte_nxt;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> (byte_count <= BUF_C));
  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> (byte_count == $past(byte_count) + 1'b1));
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> $stable(byte_count));
  // R3
  sync_src_chk: assert property (@(posedge clk) disable iff (rst)
    sync_err |-> ($past(st) == ST_HUNT));
endmodule

// File: tb/sim_usbls_rx.sv
module sim_usbls_rx;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BUFN = 4;
  localparam logic [1:0] LJ   = 2'b01;
  localparam logic [1:0] LK   = 2'b10;
  localparam logic [1:0] LSE0 = 2'b00;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dp  = 1'b0;
  logic       dm  = 1'b1;
  logic       byte_vld, pkt_done, sync_err, ovf_err;
  logic [7:0] byte_data, rd_data;
  logic [2:0] byte_count;
  logic [1:0] rd_addr = '0;

  int n_chk = 0, n_fail = 0;
  int per10 = 110, acc10 = 0, used = 0;
  logic [7:0] tx_q[$];
  logic [7:0] exp_q[$];
  int exp_done = 0, exp_cnt = 0, exp_sync = 0, exp_ovf = 0;

  always #2.5 clk = ~clk;

  usbls_rx #(.BIT_CLKS(11), .SYNC_WAIT(40), .BUF_BYTES(BUFN)) u0 (
    .clk(clk), .rst(rst), .dp(dp), .dm(dm),
    .byte_vld(byte_vld), .byte_data(byte_data), .pkt_done(pkt_done),
    .byte_count(byte_count), .sync_err(sync_err), .ovf_err(ovf_err),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // reference model: events expected from the transmitted stream
  always @(negedge clk) begin
    if (!rst) begin
      if (byte_vld) begin
        if (exp_q.size() == 0) check("R5 unexpected byte strobe", 1, 0);
        else check("R5 R4 byte value", int'(byte_data), int'(exp_q.pop_front()));
      end
      if (pkt_done) begin
        if (exp_done == 0) check("R7 unexpected done", 1, 0);
        else begin
          exp_done--;
          check("R8 byte count at done", int'(byte_count), exp_cnt);
        end
      end
      if (sync_err) begin
        if (exp_sync == 0) check("R3 unexpected sync error", 1, 0);
        else exp_sync--;
      end
      if (ovf_err) begin
        if (exp_ovf == 0) check("R9 unexpected overflow", 1, 0);
        else exp_ovf--;
      end
    end
  end

  // hold one line state for one sender bit period (tenths of a clock)
  task automatic hold_bit(input logic [1:0] s);
    int n;
    acc10 += per10;
    n = acc10 / 10 - used;
    used += n;
    {dp, dm} = s;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_packet(input bit prefix, input bit skip_stuff, input int tail);
    logic [1:0] lv;
    int ones, nb;
    acc10 = 0;
    used  = 0;
    nb    = tx_q.size();
    repeat (2) hold_bit(LJ);
    if (prefix) begin hold_bit(LK); hold_bit(LJ); hold_bit(LJ); end
    for (int k = 0; k < 8; k++) hold_bit(((k % 2) == 1 && k != 7) ? LJ : LK);
    lv = LK;
    ones = 1;
    for (int x = 0; x < nb; x++) begin
      for (int i = 0; i < 8; i++) begin
        if (tx_q[x][i]) ones++;
        else begin ones = 0; lv = ~lv; end
        hold_bit(lv);
        if (ones == 6) begin
          if (!(skip_stuff && x == nb - 1 && i == 7)) begin lv = ~lv; hold_bit(lv); end
          ones = 0;
        end
      end
    end
    for (int t = 0; t < tail; t++) begin lv = ~lv; hold_bit(lv); end
    hold_bit(LSE0);
    hold_bit(LSE0);
    repeat (3) hold_bit(LJ);
  endtask

  task automatic run_case(input string tag, input int per, input bit prefix,
                          input bit skip_stuff, input int tail);
    int n;
    n = tx_q.size();
    per10 = per;
    for (int i = 0; i < n && i < BUFN; i++) exp_q.push_back(tx_q[i]);
    if (n > BUFN) exp_ovf++;
    else begin exp_done++; exp_cnt = n; end
    send_packet(prefix, skip_stuff, tail);
    repeat (30) @(posedge clk);
    #1;
    check({tag, " bytes outstanding"}, exp_q.size(), 0);
    check({tag, " done outstanding"}, exp_done, 0);
    check({tag, " overflow outstanding"}, exp_ovf, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 1, 0);
    report();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R12
    check("R12 byte_vld in reset", byte_vld, 0);
    check("R12 pkt_done in reset", pkt_done, 0);
    check("R12 sync_err in reset", sync_err, 0);
    check("R12 ovf_err in reset", ovf_err, 0);
    check("R12 byte_count in reset", byte_count, 0);
    @(posedge clk); #1;

    // R1 R2 R4 R5: plain packet, nominal rate
    tx_q = {8'hC3, 8'hA5};
    run_case("R1 R2 basic", 110, 1'b0, 1'b0, 0);
    check("R8 count held", byte_count, 2);

    // R6: long runs of ones need stuffed bits
    tx_q = {8'hFF, 8'hFF, 8'h7E};
    run_case("R6 stuffing", 110, 1'b0, 1'b0, 0);

    // R10: read back the buffer
    for (int i = 0; i < 3; i++) begin
      rd_addr = 2'(i);
      @(posedge clk);
      @(negedge clk);
      check("R10 buffer readback", rd_data, tx_q[i]);
    end
    @(posedge clk); #1;

    // R11: slow and fast senders
    tx_q = {8'hFF, 8'h00, 8'h55};
    run_case("R11 slow", 111, 1'b0, 1'b0, 0);
    tx_q = {8'h0F, 8'hF0, 8'hFE, 8'h81};
    run_case("R11 fast", 109, 1'b0, 1'b0, 0);

    // R7: SE0 where a stuffed bit was due
    tx_q = {8'hFC};
    run_case("R7 se0 at stuff", 110, 1'b0, 1'b1, 0);

    // R7: partial byte dropped
    tx_q = {8'h12, 8'h34};
    run_case("R7 partial tail", 110, 1'b0, 1'b0, 3);

    // R2: broken start, search resumes
    tx_q = {8'h5A};
    run_case("R2 resume search", 110, 1'b1, 1'b0, 0);

    // R9: overflow then recovery
    tx_q = {8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    run_case("R9 overflow", 110, 1'b0, 1'b0, 0);
    check("R9 count after overflow", byte_count, 4);
    tx_q = {8'h99};
    run_case("R9 recovery", 110, 1'b0, 1'b0, 0);

    // R3: lone K, no sync follows
    per10 = 110; acc10 = 0; used = 0;
    exp_sync = 1;
    hold_bit(LK);
    repeat (8) hold_bit(LJ);
    check("R3 sync error seen", exp_sync, 0);
    check("R3 no byte output", exp_q.size(), 0);
    tx_q = {8'hE7};
    run_case("R3 after timeout", 110, 1'b0, 1'b0, 0);

    report();
  end
endmodule